// File: doc/BRIEF.md
# State-Indexed Gate Pattern Generator

This block drives a bank of sixteen gate lines from a table of sixteen stored patterns. Each pattern belongs to one sequencer state. An internal 4-bit state index points at the pattern in use. A step pulse from an outside sequencer advances the index, and a load input can set it directly. The selected pattern is registered before it reaches the gate pins, so the pins switch cleanly from one pattern to the next.

A simple write port loads the table and an 8-bit control register. The port carries a strobe, a 4-bit subaddress, a 5-bit function code and 16 data bits, in the style of a crate dataway. The control register has three jobs:

- It can put the free-running system clock onto gate 15.
- It can put an external count-active level onto gate 16.
- It picks one of the sixteen finished gate lines to copy onto a separate marker pin, so the marker stays in step with what leaves the block.

Top module: `gpg_gate_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, every pattern entry, the control register, the gate register and the state index clear to zero. As a result all gates are off and the marker copies gate 1.
- R2: Bit k of the pattern for the current state drives `gate_o[k]`, which is gate k+1. A change of state index at edge n shows on the gates at edge n+1.
- R3: A strobed write with function code 16 (5'b10000) loads `wr_data_i[15:0]` into the pattern entry named by `wr_addr_i`, at the same edge.
- R4: A strobed write with function code 17 (5'b10001) and subaddress 0 loads `wr_data_i[7:0]` into the control register, at the same edge.
- R5: These writes change nothing: a write with the strobe low, any function code other than 16 or 17, or function code 17 with a nonzero subaddress.
- R6: A step pulse without a load increments the state index by one at the next edge, wrapping from 15 to 0. With neither step nor load, the index holds.
- R7: A load pulse sets the state index to `load_val_i` at the next edge. It takes priority over a step in the same cycle.
- R8: Control bits 3..0 select which finished gate line, after the substitutions of R9 and R10, is copied to `marker_o`. The code n selects `gate_o[n]`.
- R9: When control bit 4 is 1, `gate_o[14]` carries the level of `clk`. When it is 0, the pin carries the pattern bit.
- R10: When control bit 5 is 1, `gate_o[15]` carries `cnt_active_i`. When it is 0, the pin carries the pattern bit.
- R11: A pattern write and a step or load in the same cycle both take effect. If the write targets the new state, its data appears on the gates one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source substituted onto gate 15 |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Advance the state index by one |
| load_i | input | 1 | Load the state index from `load_val_i` |
| load_val_i | input | 4 | State index value to load |
| wr_stb_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write subaddress |
| wr_func_i | input | 5 | Write function code |
| wr_data_i | input | 16 | Write data |
| cnt_active_i | input | 1 | Count-active level that may replace gate 16 |
| gate_o | output | 16 | Gate outputs, bit 0 being gate 1 |
| marker_o | output | 1 | Copy of the selected finished gate line |
| state_o | output | 4 | Current state index |

## Verification
The delicate overlap is a pattern write that lands in the same cycle as a step or load. The write may target the state being left or the state being entered. The bench provokes this on purpose: it rewrites the entry for the next state while stepping, and it mixes writes and steps at random for several hundred cycles. A behavioural model then applies the write and the index update at the same edge and expects the new data one edge later. A second overlap is a control write that changes the marker selection while the gates are also changing pattern. The model recomputes the marker from the substituted gate vector in every half cycle, so both overlaps are judged cycle by cycle.

// File: rtl/gpg_pkg.sv
// Package: shared constants and types for the gate pattern generator.
// Assumes function codes are 5 bits wide, as on a crate dataway.
package gpg_pkg;

    localparam int unsigned FUNC_W      = 5;
    localparam logic [FUNC_W-1:0] FN_PATTERN = 5'd16;
    localparam logic [FUNC_W-1:0] FN_CONTROL = 5'd17;

    // Decoded meaning of one write cycle
    typedef enum logic [1:0] {
        WOP_NONE    = 2'd0,
        WOP_PATTERN = 2'd1,
        WOP_CONTROL = 2'd2
    } wr_op_e;

endpackage

// File: rtl/gpg_state_ctr.sv
// Module: state index counter.
// Steps by one on step_i and wraps naturally at 2**STATE_W.
// load_i takes priority over step_i. Synchronous active-low reset.
module gpg_state_ctr #(
    parameter int unsigned STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] load_val_i,
    output logic [STATE_W-1:0] state_o
);

    logic [STATE_W-1:0] state_q;

    // Update the index: reset, then load, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= load_val_i;
        end else if (step_i) begin
            state_q <= state_q + STATE_W'(1);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/gpg_regbank.sv
// Module: write decode plus the pattern table and the control register.
// Assumes the subaddress width equals the state index width.
// A control write needs subaddress 0. Writes take effect at the edge
// on which the strobe is sampled.
module gpg_regbank
    import gpg_pkg::*;
#(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned N_GATES = 16,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_stb_i,
    input  logic [STATE_W-1:0]                   wr_addr_i,
    input  logic [FUNC_W-1:0]                    wr_func_i,
    input  logic [DATA_W-1:0]                    wr_data_i,
    output logic [(2**STATE_W)-1:0][N_GATES-1:0] pat_o,
    output logic [CTRL_W-1:0]                    ctrl_o
);

    localparam int unsigned N_STATES = 2 ** STATE_W;

    wr_op_e             op;
    logic [N_GATES-1:0] pat_q [N_STATES];
    logic [CTRL_W-1:0]  ctrl_q;

    // Classify the current write cycle
    always_comb begin
        op = WOP_NONE;
        if (wr_stb_i) begin
            if (wr_func_i == FN_PATTERN) begin
                op = WOP_PATTERN;
            end else if (wr_func_i == FN_CONTROL && wr_addr_i == '0) begin
                op = WOP_CONTROL;
            end
        end
    end

    // Pattern table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_STATES; s++) begin
                pat_q[s] <= '0;
            end
        end else if (op == WOP_PATTERN) begin
            pat_q[wr_addr_i] <= wr_data_i[N_GATES-1:0];
        end
    end

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (op == WOP_CONTROL) begin
            ctrl_q <= wr_data_i[CTRL_W-1:0];
        end
    end

    // Present the table as a packed bank
    for (genvar s = 0; s < N_STATES; s++) begin : g_pat_out
        assign pat_o[s] = pat_q[s];
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/gpg_out_stage.sv
// Module: registered pattern lookup, late gate substitution and marker mux.
// The pattern is registered so that gate lines switch together.
// The clock and count-active substitutions are combinational, so they
// pass straight through. Assumes N_GATES is at least 2 and that the
// control word holds the select field plus two substitution enables.
module gpg_out_stage #(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned N_GATES = 16,
    parameter int unsigned CTRL_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [STATE_W-1:0]                   state_i,
    input  logic [(2**STATE_W)-1:0][N_GATES-1:0] pat_i,
    input  logic [CTRL_W-1:0]                    ctrl_i,
    input  logic                                 cnt_active_i,
    output logic [N_GATES-1:0]                   raw_o,
    output logic [N_GATES-1:0]                   gate_o,
    output logic                                 marker_o
);

    localparam int unsigned SEL_W   = $clog2(N_GATES);
    localparam int unsigned CLK_BIT = SEL_W;
    localparam int unsigned CNT_BIT = SEL_W + 1;
    localparam int unsigned CLK_IDX = N_GATES - 2;
    localparam int unsigned CNT_IDX = N_GATES - 1;

    logic [N_GATES-1:0] raw_q;
    logic [SEL_W-1:0]   sel;
    logic               ctrl_unused;

    // Capture the active pattern one edge after the index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= pat_i[state_i];
        end
    end

    // Per-gate output: substitute or pass the pattern bit
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        if (g == CLK_IDX) begin : g_clk_sub
            assign gate_o[g] = ctrl_i[CLK_BIT] ? clk : raw_q[g];
        end else if (g == CNT_IDX) begin : g_cnt_sub
            assign gate_o[g] = ctrl_i[CNT_BIT] ? cnt_active_i : raw_q[g];
        end else begin : g_plain
            assign gate_o[g] = raw_q[g];
        end
    end

    assign sel         = ctrl_i[SEL_W-1:0];
    assign marker_o    = gate_o[sel];
    assign raw_o       = raw_q;
    assign ctrl_unused = &{1'b0, ctrl_i[CTRL_W-1:CNT_BIT+1]};

endmodule

// File: rtl/gpg_gate_gen.sv
// Module: top level of the state-indexed gate pattern generator.
// It connects the index counter, the register bank and the output stage.
// Assumes the subaddress width equals the state index width.
module gpg_gate_gen
    import gpg_pkg::*;
#(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned N_GATES = 16,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               load_i,
    input  logic [STATE_W-1:0] load_val_i,
    input  logic               wr_stb_i,
    input  logic [STATE_W-1:0] wr_addr_i,
    input  logic [FUNC_W-1:0]  wr_func_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               cnt_active_i,
    output logic [N_GATES-1:0] gate_o,
    output logic               marker_o,
    output logic [STATE_W-1:0] state_o
);

    localparam int unsigned N_STATES = 2 ** STATE_W;

    logic [N_STATES-1:0][N_GATES-1:0] pat;
    logic [CTRL_W-1:0]                ctrl_q;
    logic [STATE_W-1:0]               state;
    logic [N_GATES-1:0]               raw_gate;

    gpg_state_ctr #(.STATE_W(STATE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .state_o    (state)
    );

    gpg_regbank #(
        .STATE_W (STATE_W),
        .N_GATES (N_GATES),
        .CTRL_W  (CTRL_W),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb_i),
        .wr_addr_i (wr_addr_i),
        .wr_func_i (wr_func_i),
        .wr_data_i (wr_data_i),
        .pat_o     (pat),
        .ctrl_o    (ctrl_q)
    );

    gpg_out_stage #(
        .STATE_W (STATE_W),
        .N_GATES (N_GATES),
        .CTRL_W  (CTRL_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state),
        .pat_i        (pat),
        .ctrl_i       (ctrl_q),
        .cnt_active_i (cnt_active_i),
        .raw_o        (raw_gate),
        .gate_o       (gate_o),
        .marker_o     (marker_o)
    );

    assign state_o = state;

endmodule

// File: rtl/gpg_checker.sv
// Module: temporal checks for gpg_gate_gen, attached with bind below.
module gpg_checker
    import gpg_pkg::*;
#(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned N_GATES = 16,
    parameter int unsigned CTRL_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_i,
    input logic               load_i,
    input logic [STATE_W-1:0] load_val_i,
    input logic               wr_stb_i,
    input logic [STATE_W-1:0] wr_addr_i,
    input logic [FUNC_W-1:0]  wr_func_i,
    input logic               cnt_active_i,
    input logic [N_GATES-1:0] gate_o,
    input logic [N_GATES-1:0] raw_gate,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic [STATE_W-1:0] state_o
);

    localparam int unsigned CNT_BIT = $clog2(N_GATES) + 1;

    // R1: reset clears the index and the gate register
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == '0 && raw_gate == '0 && ctrl_q == '0));

    // R6: a lone step increments the index, with wrap
    p_step_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> state_o == $past(state_o) + STATE_W'(1));

    // R6: with no step and no load, the index holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(state_o));

    // R7: a load wins and sets the index
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_o == $past(load_val_i));

    // R5: non-control writes leave the control register alone
    p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_i && wr_func_i == FN_CONTROL && wr_addr_i == '0)
        |=> $stable(ctrl_q));

    // R10: count-active substitution on the last gate
    p_cnt_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CNT_BIT] |-> gate_o[N_GATES-1] == cnt_active_i);

endmodule

bind gpg_gate_gen gpg_checker #(
    .STATE_W (STATE_W),
    .N_GATES (N_GATES),
    .CTRL_W  (CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .wr_stb_i     (wr_stb_i),
    .wr_addr_i    (wr_addr_i),
    .wr_func_i    (wr_func_i),
    .cnt_active_i (cnt_active_i),
    .gate_o       (gate_o),
    .raw_gate     (raw_gate),
    .ctrl_q       (ctrl_q),
    .state_o      (state_o)
);

// File: tb/tb_gpg_gate_gen.sv
module tb_gpg_gate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        load_i = 1'b0;
    logic [3:0]  load_val_i = '0;
    logic        wr_stb_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [4:0]  wr_func_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        cnt_active_i = 1'b0;
    logic [15:0] gate_o;
    logic        marker_o;
    logic [3:0]  state_o;

    gpg_gate_gen dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .load_i(load_i),
        .load_val_i(load_val_i), .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i),
        .wr_func_i(wr_func_i), .wr_data_i(wr_data_i),
        .cnt_active_i(cnt_active_i), .gate_o(gate_o), .marker_o(marker_o),
        .state_o(state_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string tag = "R1 reset";

    // Behavioural reference model
    int m_pat [16];
    int m_ctrl  = 0;
    int m_state = 0;
    int m_gate  = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            foreach (m_pat[i]) m_pat[i] = 0;
            m_ctrl = 0; m_state = 0; m_gate = 0;
        end else begin
            m_gate = m_pat[m_state];
            if (load_i) m_state = int'(load_val_i);
            else if (step_i) m_state = (m_state + 1) % 16;
            if (wr_stb_i) begin
                if (wr_func_i == 5'd16) m_pat[wr_addr_i] = int'(wr_data_i);
                else if (wr_func_i == 5'd17 && wr_addr_i == 4'd0)
                    m_ctrl = int'(wr_data_i[7:0]);
            end
        end
    endtask

    task automatic compare(input int clk_lvl);
        int g;
        g = m_gate;
        if ((m_ctrl & 16) != 0) g = clk_lvl != 0 ? (g | 16'h4000) : (g & 16'hBFFF);
        if ((m_ctrl & 32) != 0) g = cnt_active_i ? (g | 16'h8000) : (g & 16'h7FFF);
        chk("R2 gates", int'(gate_o), g);
        chk("R8 marker", int'(marker_o), (g >> (m_ctrl & 15)) & 1);
        chk("R6 state", int'(state_o), m_state);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2 compare(1);
        @(negedge clk);
        #2 compare(0);
    endtask

    task automatic idle();
        step_i = 0; load_i = 0; wr_stb_i = 0;
    endtask

    task automatic wr(input int f, input int a, input int d);
        wr_stb_i = 1; wr_func_i = 5'(f); wr_addr_i = 4'(a); wr_data_i = 16'(d);
        cyc();
        wr_stb_i = 0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        tag = "R3 pattern write";
        for (int s = 0; s < 16; s++) wr(16, s, ((s * 16'h0F1D) ^ 16'hA5C3) & 16'hFFFF);
        cyc(); cyc();
        tag = "R6 step wrap";
        for (int k = 0; k < 18; k++) begin step_i = 1; cyc(); end
        idle(); cyc(); cyc();
        tag = "R5 ignored writes";
        wr(0, 2, 16'hFFFF); wr(18, 3, 16'h1234); wr(31, 0, 16'h00FF);
        wr(17, 3, 16'h003F);
        wr_func_i = 5'd16; wr_addr_i = 4'd2; wr_data_i = 16'hDEAD; cyc();
        cyc();
        tag = "R7 load priority";
        load_i = 1; load_val_i = 4'd9; cyc();
        step_i = 1; load_val_i = 4'd4; cyc();
        idle(); cyc(); cyc();
        tag = "R4 R8 marker select";
        for (int s = 0; s < 16; s++) begin
            wr(17, 0, s); cyc();
            step_i = 1; cyc(); idle(); cyc();
        end
        tag = "R9 clock on gate 15";
        wr(17, 0, 16'h001E); cyc(); cyc();
        tag = "R10 count active on gate 16";
        wr(17, 0, 16'h003F);
        for (int k = 0; k < 6; k++) begin cnt_active_i = ~cnt_active_i; cyc(); end
        tag = "R11 write with step";
        wr_stb_i = 1; wr_func_i = 5'd16; wr_addr_i = 4'((state_o + 1) % 16);
        wr_data_i = 16'h5AA5; step_i = 1; cyc();
        idle(); cyc(); cyc();
        tag = "R11 R2 random mix";
        for (int k = 0; k < 400; k++) begin
            step_i = $urandom_range(0, 1) == 1;
            load_i = $urandom_range(0, 7) == 0;
            load_val_i = 4'($urandom);
            wr_stb_i = $urandom_range(0, 1) == 1;
            wr_func_i = 5'($urandom_range(14, 18));
            wr_addr_i = 4'($urandom);
            wr_data_i = 16'($urandom);
            cnt_active_i = $urandom_range(0, 1) == 1;
            cyc();
        end
        idle();
        tag = "R1 reset again";
        rst_n = 0; cyc(); cyc();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule